// File: doc/BRIEF.md
# Oscillator clock recovery trimming controller

This block keeps a 48 MHz on-chip oscillator centred on its nominal frequency by comparing it against a much slower reference event train, such as a 1 kHz frame-start marker. A 16-bit error counter, clocked by the oscillator, is reloaded at every reference event and counts down towards zero. Zero is the moment the next event should arrive. If the event comes early, the remaining down-count is the error and the oscillator is slow. If the counter reaches zero first, it turns round and counts up, and the up-count at the event is the error with the oscillator too fast.

At each event the error and its direction are captured. The error is graded against a programmable limit into three tiers: OK, warning and sync error. Sticky status flags are set to match, and when automatic mode is on the 6-bit trim code is stepped by one or two towards the nominal frequency, saturating at both ends. A reference that stops coming is reported as a missed sync. Each interrupt request is its flag gated by an enable bit.

Software reaches the block through a single-cycle register port. Every write is taken on the clock edge where `bus_we` is high, so the port has no back-pressure. Reads are combinational from `bus_addr`. The reference may come from one of three pins, on either edge, prescaled by a power of two, or it can be raised from software.

Top module: `osc_trim_ctrl`

Register map (bus_addr): 0 = control, 1 = configuration, 2 = status (read only), 3 = clear (write one to clear, reads 0).
Control: bit0 counter enable, bit1 automatic trim, bit2 software sync (reads 0), bits[7:4] interrupt enables (OK, warning, error, expected-sync), bits[13:8] trim code.
Configuration: bits[15:0] reload, bits[23:16] limit, bits[26:24] prescale exponent, bits[28:27] source select, bit29 falling-edge polarity.
Status: bit0 OK, bit1 warning, bit2 combined error, bit3 expected-sync, bit4 sync error, bit5 sync miss, bit6 trim overflow, bit7 direction, bits[31:16] captured error.
Clear: bit0 OK, bit1 warning, bit2 all three error sources, bit3 expected-sync.

## Requirements
- R1: After reset the control register reads 0x00002000, so the trim is 32 and everything is disabled. The configuration register reads 0x1022BB7F: reload 0xBB7F, limit 0x22, prescale 0, source 2, rising edge. Status reads 0 and all interrupt outputs are low.
- R2: While the counter enable bit is 1, writes to the configuration register are ignored. While it is 0 they take effect.
- R3: The counter is loaded with reload on the edge that enables it and on every reference event. It then decrements once per clock. After reaching 0 it increments from 1. An event captures the current count into status bits[31:16], with bit7 = 1 if it was counting down (slow) and 0 if counting up (fast).
- R4: When the down-count sits at 0 on an edge without an event, the expected-sync flag (status bit3) sets.
- R5: Each captured error E is graded against the limit L. If E < L, OK (bit0) sets. If L <= E < 3L, warning (bit1) sets. If E >= 3L, sync error (bit4) sets.
- R6: With automatic trim on, a warning moves the trim by 1 and a sync error moves it by 2. The trim moves up when the direction is slow and down when it is fast. An OK result leaves the trim unchanged.
- R7: Trim steps clamp at 0 and 63. A step that would pass either end sets trim overflow (bit6).
- R8: If the up-count has reached 3L and no event arrives on the next edge, sync miss (bit5) sets. The counter then stops. The next event only restarts it, with no capture, no grading and no trim change.
- R9: A software write of control bits[13:8] changes the trim only if automatic trim was off before that write. Otherwise the written value is ignored.
- R10: Writing ones to the clear register clears the matching flags. Clear bit2 clears sync error, sync miss and trim overflow together, and with them combined error (status bit2 = OR of those three).
- R11: Each interrupt output equals its flag ANDed with its enable. The error interrupt covers the combined error flag.
- R12: The selected pin (source 0..2) is synchronised and edge-detected on the edge chosen by bit29. Every 2^N active edges, with N being the prescale exponent, form one event. Unselected pins have no effect.
- R13: Writing control bit2 while the counter is enabled raises one reference event on that edge. The bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock that drives the error counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, accepted on every edge |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ref_in | input | 3 | Candidate reference inputs |
| trim_code | output | 6 | Oscillator trim code |
| irq_ok | output | 1 | OK interrupt request |
| irq_warn | output | 1 | Warning interrupt request |
| irq_err | output | 1 | Combined error interrupt request |
| irq_esync | output | 1 | Expected-sync interrupt request |

## Verification
The checker watches five things on every cycle:
- the configuration freezes while counting;
- the capture moves only on an event;
- an automatic trim change never exceeds two codes, and a manual trim never drifts without a write;
- overflow rises only at a rail;
- a miss rises only out of the up-count.

The tiering boundaries, the exact captured values, the expected-sync timing, saturation on both ends, the clearing groups and the pin prescaler with its polarity can only be shown by the bench. It sweeps the event arrival time cycle by cycle across the whole window, from one tick after reload through to the missed-sync case, and compares against an arithmetic model of counter, grade and trim.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    TIER_OK   = 2'd0,
    TIER_WARN = 2'd1,
    TIER_ERR  = 2'd2
  } tier_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  localparam int CTRL_EN       = 0;
  localparam int CTRL_AUTO     = 1;
  localparam int CTRL_SWSYNC   = 2;
  localparam int CTRL_IE_LSB   = 4;
  localparam int CTRL_TRIM_LSB = 8;

  localparam int ST_OK    = 0;
  localparam int ST_WARN  = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_ESYNC = 3;
  localparam int ST_SERR  = 4;
  localparam int ST_MISS  = 5;
  localparam int ST_OVF   = 6;
  localparam int ST_DIR   = 7;
  localparam int ST_CAP   = 16;
endpackage

// File: rtl/osc_ref_event.sv
module osc_ref_event #(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NSRC-1:0]  ref_in,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             fall_pol,
  input  logic [DIV_W-1:0] div_exp,
  input  logic             sw_sync,
  output logic             evt
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             sel_bit;
  logic [2:0]       sync_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic             lvl_now, lvl_prev, active, pin_evt;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_sel == SEL_W'(i)) sel_bit = ref_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sel_bit};
  end

  assign lvl_now  = sync_q[1] ^ fall_pol;
  assign lvl_prev = sync_q[2] ^ fall_pol;
  assign active   = lvl_now & ~lvl_prev;
  assign pre_last = PRE_W'((1 << div_exp) - 1);
  assign pin_evt  = active && (pre_q == pre_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!en)    pre_q <= '0;
    else if (active) pre_q <= pin_evt ? '0 : pre_q + 1'b1;
  end

  assign evt = en & (pin_evt | sw_sync);
endmodule

// File: rtl/osc_err_counter.sv
module osc_err_counter
  import osc_trim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic [CNT_W-1:0] reload,
  input  logic [LIM_W-1:0] limit,
  output logic             eval_o,
  output tier_e            tier_o,
  output logic             slow_o,
  output logic             esync_o,
  output logic             miss_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             dir_o,
  output logic             down_o
);
  localparam int L3_W  = LIM_W + 2;
  localparam int CMP_W = (CNT_W > L3_W) ? CNT_W : L3_W;

  logic [CNT_W-1:0] cnt_q;
  logic             down_q, lost_q;
  logic [L3_W-1:0]  lim3;
  logic [CMP_W-1:0] cnt_x, lim_x, lim3_x;
  logic             at_zero, past_win;

  assign lim3     = ({2'b00, limit} << 1) + {2'b00, limit};
  assign cnt_x    = CMP_W'(cnt_q);
  assign lim_x    = CMP_W'(limit);
  assign lim3_x   = CMP_W'(lim3);
  assign at_zero  = (cnt_q == '0);
  assign past_win = (cnt_x >= lim3_x);

  assign eval_o  = en & evt & ~lost_q;
  assign esync_o = en & ~evt & ~lost_q & down_q & at_zero;
  assign miss_o  = en & ~evt & ~lost_q & ~down_q & past_win;
  assign slow_o  = down_q;
  assign down_o  = down_q;

  always_comb begin
    if (cnt_x < lim_x)       tier_o = TIER_OK;
    else if (cnt_x < lim3_x) tier_o = TIER_WARN;
    else                     tier_o = TIER_ERR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b1;
      lost_q <= 1'b0;
      cap_o  <= '0;
      dir_o  <= 1'b0;
    end else if (!en) begin
      cnt_q  <= reload;
      down_q <= 1'b1;
      lost_q <= 1'b0;
    end else if (evt) begin
      if (!lost_q) begin
        cap_o <= cnt_q;
        dir_o <= down_q;
      end
      cnt_q  <= reload;
      down_q <= 1'b1;
      lost_q <= 1'b0;
    end else if (!lost_q) begin
      if (down_q) begin
        if (at_zero) begin
          down_q <= 1'b0;
          cnt_q  <= CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (past_win) begin
        lost_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osc_trim_adj.sv
module osc_trim_adj
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              eval,
  input  tier_e             tier,
  input  logic              slow,
  input  logic              sw_we,
  input  logic [TRIM_W-1:0] sw_val,
  output logic [TRIM_W-1:0] trim_q,
  output logic              ovf_set
);
  localparam int SUM_W = TRIM_W + 2;
  localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(1 << (TRIM_W - 1));
  localparam logic [SUM_W-1:0]  TRIM_MAX = SUM_W'((1 << TRIM_W) - 1);

  logic [1:0]        step;
  logic [SUM_W-1:0]  wide, up_sum;
  logic [TRIM_W-1:0] nxt;
  logic              clamp;

  always_comb begin
    case (tier)
      TIER_WARN: step = 2'd1;
      TIER_ERR:  step = 2'd2;
      default:   step = 2'd0;
    endcase
  end

  assign wide   = SUM_W'(trim_q);
  assign up_sum = wide + SUM_W'(step);

  always_comb begin
    clamp = 1'b0;
    nxt   = trim_q;
    if (slow) begin
      if (up_sum > TRIM_MAX) begin
        clamp = 1'b1;
        nxt   = TRIM_MAX[TRIM_W-1:0];
      end else begin
        nxt = up_sum[TRIM_W-1:0];
      end
    end else begin
      if (wide < SUM_W'(step)) begin
        clamp = 1'b1;
        nxt   = '0;
      end else begin
        nxt = trim_q - TRIM_W'(step);
      end
    end
  end

  assign ovf_set = auto_en & eval & clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               trim_q <= TRIM_RST;
    else if (auto_en && eval) trim_q <= nxt;
    else if (sw_we && !auto_en) trim_q <= sw_val;
  end
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LIM_W      = 8,
  parameter int TRIM_W     = 6,
  parameter int DIV_W      = 3,
  parameter int NSRC       = 3,
  parameter int SEL_W      = 2,
  parameter int RELOAD_RST = 'hBB7F,
  parameter int LIMIT_RST  = 'h22,
  parameter int SRC_RST    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   ref_in,
  output logic [TRIM_W-1:0] trim_code,
  output logic              irq_ok,
  output logic              irq_warn,
  output logic              irq_err,
  output logic              irq_esync
);
  localparam int LIM_LSB = CNT_W;
  localparam int DIV_LSB = LIM_LSB + LIM_W;
  localparam int SRC_LSB = DIV_LSB + DIV_W;
  localparam int POL_BIT = SRC_LSB + SEL_W;
  localparam int CFG_W   = POL_BIT + 1;
  localparam logic [CFG_W-1:0] CFG_RST =
    (CFG_W'(SRC_RST) << SRC_LSB) | (CFG_W'(LIMIT_RST) << LIM_LSB) | CFG_W'(RELOAD_RST);

  logic             cnt_en_q, auto_q;
  logic [3:0]       ie_q;
  logic [CFG_W-1:0] cfg_q;
  logic             wr_ctrl, wr_cfg, sw_sync;
  logic [3:0]       clr;
  logic             evt, eval, slow, esync_set, miss_set, ovf_set, cnt_down;
  tier_e            tier;
  logic [CNT_W-1:0] cap_q;
  logic             dir_q;
  logic             f_ok, f_warn, f_esync, f_serr, f_miss, f_ovf, f_err;
  logic             unused_wdata;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == ADDR_CFG);
  assign sw_sync = wr_ctrl && bus_wdata[CTRL_SWSYNC];
  assign clr     = (bus_we && (bus_addr == ADDR_CLR)) ? bus_wdata[3:0] : 4'b0000;
  assign unused_wdata = ^bus_wdata[31:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en_q <= 1'b0;
      auto_q   <= 1'b0;
      ie_q     <= '0;
      cfg_q    <= CFG_RST;
    end else begin
      if (wr_ctrl) begin
        cnt_en_q <= bus_wdata[CTRL_EN];
        auto_q   <= bus_wdata[CTRL_AUTO];
        ie_q     <= bus_wdata[CTRL_IE_LSB +: 4];
      end
      if (wr_cfg && !cnt_en_q) cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  osc_ref_event #(.NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cnt_en_q),
    .ref_in   (ref_in),
    .src_sel  (cfg_q[SRC_LSB +: SEL_W]),
    .fall_pol (cfg_q[POL_BIT]),
    .div_exp  (cfg_q[DIV_LSB +: DIV_W]),
    .sw_sync  (sw_sync),
    .evt      (evt)
  );

  osc_err_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en_q),
    .evt     (evt),
    .reload  (cfg_q[0 +: CNT_W]),
    .limit   (cfg_q[LIM_LSB +: LIM_W]),
    .eval_o  (eval),
    .tier_o  (tier),
    .slow_o  (slow),
    .esync_o (esync_set),
    .miss_o  (miss_set),
    .cap_o   (cap_q),
    .dir_o   (dir_q),
    .down_o  (cnt_down)
  );

  osc_trim_adj #(.TRIM_W(TRIM_W)) u_trim (
    .clk     (clk),
    .rst_n   (rst_n),
    .auto_en (auto_q),
    .eval    (eval),
    .tier    (tier),
    .slow    (slow),
    .sw_we   (wr_ctrl),
    .sw_val  (bus_wdata[CTRL_TRIM_LSB +: TRIM_W]),
    .trim_q  (trim_code),
    .ovf_set (ovf_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_ok    <= 1'b0;
      f_warn  <= 1'b0;
      f_esync <= 1'b0;
      f_serr  <= 1'b0;
      f_miss  <= 1'b0;
      f_ovf   <= 1'b0;
    end else begin
      f_ok    <= (eval && tier == TIER_OK)   | (f_ok    & ~clr[0]);
      f_warn  <= (eval && tier == TIER_WARN) | (f_warn  & ~clr[1]);
      f_serr  <= (eval && tier == TIER_ERR)  | (f_serr  & ~clr[2]);
      f_miss  <= miss_set                    | (f_miss  & ~clr[2]);
      f_ovf   <= ovf_set                     | (f_ovf   & ~clr[2]);
      f_esync <= esync_set                   | (f_esync & ~clr[3]);
    end
  end

  assign f_err     = f_serr | f_miss | f_ovf;
  assign irq_ok    = f_ok    & ie_q[0];
  assign irq_warn  = f_warn  & ie_q[1];
  assign irq_err   = f_err   & ie_q[2];
  assign irq_esync = f_esync & ie_q[3];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CTRL_EN]                    = cnt_en_q;
        bus_rdata[CTRL_AUTO]                  = auto_q;
        bus_rdata[CTRL_IE_LSB +: 4]           = ie_q;
        bus_rdata[CTRL_TRIM_LSB +: TRIM_W]    = trim_code;
      end
      ADDR_CFG:  bus_rdata[CFG_W-1:0] = cfg_q;
      ADDR_STAT: begin
        bus_rdata[ST_OK]            = f_ok;
        bus_rdata[ST_WARN]          = f_warn;
        bus_rdata[ST_ERR]           = f_err;
        bus_rdata[ST_ESYNC]         = f_esync;
        bus_rdata[ST_SERR]          = f_serr;
        bus_rdata[ST_MISS]          = f_miss;
        bus_rdata[ST_OVF]           = f_ovf;
        bus_rdata[ST_DIR]           = dir_q;
        bus_rdata[ST_CAP +: CNT_W]  = cap_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
  parameter int TRIM_W = 6,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [TRIM_W-1:0] trim_code,
  input logic              auto_q,
  input logic              cnt_en_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              evt,
  input logic [CNT_W-1:0]  cap_q,
  input logic              dir_q,
  input logic              f_ovf,
  input logic              f_miss,
  input logic              cnt_down
);
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_q |=> $stable(cfg_q));

  p_capture_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(cap_q) && $stable(dir_q)));

  p_trim_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q |=> ((trim_code - $past(trim_code) + TRIM_W'(2)) <= TRIM_W'(4)));

  p_ovf_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ovf) |-> (trim_code == '0 || trim_code == {TRIM_W{1'b1}}));

  p_miss_from_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_miss) |-> !$past(cnt_down));

  p_manual_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_q && !(bus_we && bus_addr == 2'd0)) |=> $stable(trim_code));
endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(
  .TRIM_W (TRIM_W),
  .CNT_W  (CNT_W),
  .CFG_W  (CFG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .trim_code (trim_code),
  .auto_q    (auto_q),
  .cnt_en_q  (cnt_en_q),
  .cfg_q     (cfg_q),
  .evt       (evt),
  .cap_q     (cap_q),
  .dir_q     (dir_q),
  .f_ovf     (f_ovf),
  .f_miss    (f_miss),
  .cnt_down  (cnt_down)
);

// File: tb/osc_trim_ctrl_bench.sv
module osc_trim_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int R = 20;
  localparam int L = 3;
  localparam logic [31:0] C_RUN = 32'h1 | 32'h2 | 32'hF0 | (32'd32 << 8);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  ref_in;
  logic [5:0]  trim_code;
  logic        irq_ok, irq_warn, irq_err, irq_esync;

  int total = 0;
  int bad = 0;
  int trim_m;
  logic [15:0] cap_m;
  logic        dir_m;
  logic [31:0] got;

  always #(CLK_P / 2) clk = ~clk;

  osc_trim_ctrl u_osc_trim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_in(ref_in),
    .trim_code(trim_code), .irq_ok(irq_ok), .irq_warn(irq_warn),
    .irq_err(irq_err), .irq_esync(irq_esync)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Clear all flags, then raise a software event n edges after the previous one.
  task automatic run_event(input int n);
    int d, err, step;
    logic slow, eval, ok, warn, serr, miss, ovf, es;
    logic [31:0] exp;
    wr(2'd3, 32'hF);
    if (n > 2) idle(n - 2);
    wr(2'd0, C_RUN | 32'h4);
    d = n - 1;
    ok = 0; warn = 0; serr = 0; miss = 0; ovf = 0; eval = 0; slow = 0; err = 0; step = 0;
    es = (d > R);
    if (d <= R) begin slow = 1; err = R - d; eval = 1; end
    else if (d - R <= 3 * L) begin slow = 0; err = d - R; eval = 1; end
    else miss = 1;
    if (eval) begin
      cap_m = 16'(err);
      dir_m = slow;
      if (err < L) begin ok = 1; step = 0; end
      else if (err < 3 * L) begin warn = 1; step = 1; end
      else begin serr = 1; step = 2; end
      if (slow) begin
        if (trim_m + step > 63) begin trim_m = 63; ovf = 1; end
        else trim_m = trim_m + step;
      end else begin
        if (trim_m - step < 0) begin trim_m = 0; ovf = 1; end
        else trim_m = trim_m - step;
      end
    end
    exp = {cap_m, 8'h00, dir_m, ovf, miss, serr, es, (serr | miss | ovf), warn, ok};
    rd(2'd2, got);
    check($sformatf("R3/R4/R5/R7/R8 status n=%0d", n), got, exp);
    check($sformatf("R6 trim n=%0d", n), {26'd0, trim_code}, 32'(trim_m));
    check($sformatf("R11 irq n=%0d", n), {28'd0, irq_esync, irq_err, irq_warn, irq_ok},
          {28'd0, es, (serr | miss | ovf), warn, ok});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ref_in = 3'b010;
    cap_m = '0; dir_m = 1'b0; trim_m = 32;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd0, got); check("R1 control", got, 32'h0000_2000);
    rd(2'd1, got); check("R1 config", got, 32'h1022_BB7F);
    rd(2'd2, got); check("R1 status", got, 32'h0);
    check("R1 trim/irq", {22'd0, trim_code, irq_esync, irq_err, irq_warn, irq_ok}, {22'd0, 6'd32, 4'd0});

    // R9 manual write, then ignored under auto
    wr(2'd0, 32'd40 << 8);
    check("R9 manual trim", {26'd0, trim_code}, 32'd40);
    wr(2'd0, 32'h2 | (32'd40 << 8));
    wr(2'd0, 32'h2 | (32'd5 << 8));
    check("R9 auto ignores write", {26'd0, trim_code}, 32'd40);
    wr(2'd0, 32'h0 | (32'd9 << 8));
    check("R9 write while auto was on", {26'd0, trim_code}, 32'd40);
    wr(2'd0, 32'd32 << 8);

    // Small configuration: reload 20, limit 3
    wr(2'd1, 32'h0003_0014);
    rd(2'd1, got); check("R2 write when idle", got, 32'h0003_0014);
    wr(2'd0, C_RUN);
    wr(2'd1, 32'h0005_0030);
    rd(2'd1, got); check("R2 locked while counting", got, 32'h0003_0014);
    wr(2'd0, C_RUN & ~32'h1);
    wr(2'd0, C_RUN);

    // Sweep every arrival time from early to past the miss window
    for (int n = 2; n <= R + 3 * L + 4; n++) run_event(n);
    rd(2'd0, got); check("R13 sync bit reads zero", {29'd0, got[2:0]}, 32'h3);

    // Saturation upward then downward
    for (int k = 0; k < 20; k++) run_event(2);
    for (int k = 0; k < 34; k++) run_event(R + 3 * L + 1);

    // R11 gating off
    wr(2'd0, C_RUN & ~32'hF0);
    check("R11 irq gated off", {28'd0, irq_esync, irq_err, irq_warn, irq_ok}, 32'h0);
    // R10 error clear group
    wr(2'd3, 32'h4);
    rd(2'd2, got); check("R10 error group cleared", got, {16'(3 * L), 8'h00, 8'h08});
    wr(2'd3, 32'h8);
    rd(2'd2, got); check("R10 esync cleared", got, {16'(3 * L), 16'h0000});

    // R12 pin path: source 1, falling edge, divide by 4
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd1000 | (32'd3 << 16) | (32'd2 << 24) | (32'd1 << 27) | (32'd1 << 29));
    rd(2'd1, got);
    check("R12 config", got, 32'd1000 | (32'd3 << 16) | (32'd2 << 24) | (32'd1 << 27) | (32'd1 << 29));
    wr(2'd0, 32'h1 | 32'hF0 | (32'(trim_m) << 8));
    wr(2'd3, 32'hF);
    for (int k = 0; k < 5; k++) begin
      ref_in[0] = 1'b1; idle(3); ref_in[0] = 1'b0; idle(3);
    end
    rd(2'd2, got); check("R12 unselected pin ignored", {31'd0, got[4]}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      ref_in[1] = 1'b0; idle(3); ref_in[1] = 1'b1; idle(3);
    end
    idle(4);
    rd(2'd2, got); check("R12 three edges no event", {31'd0, got[4]}, 32'd0);
    ref_in[1] = 1'b0;
    idle(6);
    rd(2'd2, got); check("R12 fourth falling edge event", {31'd0, got[4]}, 32'd1);
    check("R12 manual trim held", {26'd0, trim_code}, 32'(trim_m));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule